// File: doc/BRIEF.md
# Linked-List DMA Chain Walker

This block is one channel of a memory-to-device DMA engine. It follows a chain of node headers stored in memory and streams each node's payload words to a peripheral. Software loads a start pointer and sets a start bit. The walker then reads the first header and sends the payload that follows it. It moves to the node that the header points to, and it keeps going until a pointer carries the end marker.

Each header word carries two fields. The top byte holds a payload length in words. The low 24 bits hold the pointer to the next header. Memory reads use a simple request/valid port, and the walker keeps at most one read in flight. Payload leaves on a valid/ready stream. When the walk ends, the final pointer is written back into the pointer register, `busy` drops and `done` pulses.

Top module: `llchain_dma`

## Requirements
- R1: A header word is decoded as a payload length in bits 31:24 and a next-node pointer in bits 23:0.
- R2: Payload words are read starting at the header pointer plus 4, and the address steps by 4 per word. Headers and payload are fetched in strict chain order.
- R3: A header whose length is 0 sends no payload, and the walker goes straight to the next-pointer test.
- R4: After a node, the current pointer takes the header's next field. The walk stops when bit 23 of that pointer is 1. The first header is always fetched, even if the start pointer has bit 23 set.
- R5: Every address on `mem_rd_addr` equals the internal 24-bit pointer ANDed with 0x1FFFFC. The pointer itself is kept unmasked, so an unaligned start of 0x203 fetches its header at 0x200 and its first payload word at 0x204.
- R6: A control write (`cfg_sel`=1) loads the start bit from `cfg_wdata[0]`. The start bit reads 0 from the cycle in which `busy` first reads 1.
- R7: At the end of a walk, `base_ptr` holds the terminating pointer, which has bit 23 set.
- R8: A pointer write (`cfg_sel`=0) stores `cfg_wdata[23:0]` and discards bits 31:24.
- R9: `done` is high for exactly one cycle per walk. `busy` is high from the cycle after the start bit is seen until `done` rises, and it reads 0 in the `done` cycle. Both reset to 0.
- R10: While `dev_valid` is 1 and `dev_ready` is 0, `dev_valid` and `dev_data` hold. No memory read, and so no header fetch for the next node, is issued while a payload word is waiting on the output.
- R11: A read request lasts one cycle, and no new request is issued until `mem_rd_valid` has returned the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the pointer register, 1 selects the control register |
| cfg_wdata | input | 32 | Register write data |
| base_ptr | output | 24 | Pointer register contents |
| start_pend | output | 1 | Start bit of the control register |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 24 | Masked, word-aligned read address |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Read data |
| dev_valid | output | 1 | Payload word available |
| dev_data | output | 32 | Payload word |
| dev_ready | input | 1 | Peripheral accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit pointer, 32-bit words, an 8-bit length field and the 0x1FFFFC window. With these values a pointer can carry bit 22 set, which aliases inside the window, and a start pointer can be unaligned so that its low bits are dropped on the bus but still carried through the pointer arithmetic. Another chain starts at a pointer that already holds the end marker, and terminating pointers such as 0xFFFFFF test the write-back. Chains are replayed with the peripheral either always ready or withholding ready every third cycle, so stalls land in the middle of payload bursts and just before header fetches.

// File: rtl/llchain_pkg.sv
package llchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_PAY_OUT,
    ST_NEXT
  } walk_state_e;

endpackage

// File: rtl/llchain_regs.sv
module llchain_regs #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              clr_start,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_ptr,
  output logic [ADDR_W-1:0] base_ptr,
  output logic              start_pend
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic              start_q, start_d;
  logic              base_en;

  generate
    if (DATA_W > ADDR_W) begin : g_hi
      logic unused_cfg_hi;
      assign unused_cfg_hi = ^cfg_wdata[DATA_W-1:ADDR_W];
    end
  endgenerate

  // write-back from the walker takes priority over a software write
  always_comb begin
    base_en = 1'b0;
    base_d  = base_q;
    if (wb_en) begin
      base_en = 1'b1;
      base_d  = wb_ptr;
    end else if (cfg_we && !cfg_sel) begin
      base_en = 1'b1;
      base_d  = cfg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    start_d = start_q;
    if (clr_start) begin
      start_d = 1'b0;
    end else if (cfg_we && cfg_sel) begin
      start_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  assign base_ptr   = base_q;
  assign start_pend = start_q;

endmodule

// File: rtl/llchain_out.sv
module llchain_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              dev_ready,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_data,
  output logic              fire
);

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q;

  assign fire = valid_q & dev_ready;

  always_comb begin
    valid_d = valid_q;
    if (fire)    valid_d = 1'b0;
    if (load_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // data register: enable only, no reset needed
  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= load_data;
    end
  end

  assign dev_valid = valid_q;
  assign dev_data  = data_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data)))
    else $error("stalled payload word changed");

endmodule

// File: rtl/llchain_walker.sv
module llchain_walker
  import llchain_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              DATA_W    = 32,
  parameter int              CNT_W     = 8,
  parameter logic [ADDR_W-1:0] BUS_MASK = ADDR_W'('h1FFFFC)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_pend,
  input  logic [ADDR_W-1:0] base_ptr,
  output logic              clr_start,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_ptr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              load_en,
  output logic [DATA_W-1:0] load_data,
  input  logic              out_valid,
  input  logic              out_fire,
  output logic              busy,
  output logic              done
);

  localparam int              END_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [ADDR_W-1:0] hdr_next;

  assign hdr_cnt  = mem_rd_data[DATA_W-1 -: CNT_W];
  assign hdr_next = mem_rd_data[ADDR_W-1:0];

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    nxt_d     = nxt_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    clr_start = 1'b0;
    wb_en     = 1'b0;
    load_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_pend) begin
          cur_d     = base_ptr;
          clr_start = 1'b1;
          state_d   = ST_HDR_REQ;
        end
      end
      ST_HDR_REQ: state_d = ST_HDR_WAIT;
      ST_HDR_WAIT: begin
        if (mem_rd_valid) begin
          cnt_d   = hdr_cnt;
          nxt_d   = hdr_next;
          cur_d   = cur_q + STEP;
          state_d = (hdr_cnt == '0) ? ST_NEXT : ST_PAY_REQ;
        end
      end
      ST_PAY_REQ: state_d = ST_PAY_WAIT;
      ST_PAY_WAIT: begin
        if (mem_rd_valid) begin
          load_en = 1'b1;
          state_d = ST_PAY_OUT;
        end
      end
      ST_PAY_OUT: begin
        if (out_fire) begin
          cur_d   = cur_q + STEP;
          cnt_d   = cnt_q - CNT_W'(1);
          state_d = (cnt_q == CNT_W'(1)) ? ST_NEXT : ST_PAY_REQ;
        end
      end
      ST_NEXT: begin
        cur_d = nxt_q;
        if (nxt_q[END_BIT]) begin
          wb_en   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_HDR_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign mem_rd_req  = (state_q == ST_HDR_REQ) || (state_q == ST_PAY_REQ);
  assign mem_rd_addr = cur_q & BUS_MASK;
  assign load_data   = mem_rd_data;
  assign wb_ptr      = nxt_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;

  assert_hdr_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req |-> !out_valid)
    else $error("memory read issued while a payload word waits");

  assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req |=> !mem_rd_req)
    else $error("back-to-back read requests");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done)
    else $error("done wider than one cycle");

endmodule

// File: rtl/llchain_dma.sv
module llchain_dma #(
  parameter int              ADDR_W    = 24,
  parameter int              DATA_W    = 32,
  parameter int              CNT_W     = 8,
  parameter logic [ADDR_W-1:0] BUS_MASK = ADDR_W'('h1FFFFC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_ptr,
  output logic              start_pend,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_data,
  input  logic              dev_ready,
  output logic              busy,
  output logic              done
);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              clr_start, wb_en, load_en, fire;
  logic [ADDR_W-1:0] wb_ptr;
  logic [DATA_W-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  llchain_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .clr_start  (clr_start),
    .wb_en      (wb_en),
    .wb_ptr     (wb_ptr),
    .base_ptr   (base_ptr),
    .start_pend (start_pend)
  );

  llchain_walker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BUS_MASK(BUS_MASK)
  ) u_walker (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .start_pend   (start_pend),
    .base_ptr     (base_ptr),
    .clr_start    (clr_start),
    .wb_en        (wb_en),
    .wb_ptr       (wb_ptr),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .load_en      (load_en),
    .load_data    (load_data),
    .out_valid    (dev_valid),
    .out_fire     (fire),
    .busy         (busy),
    .done         (done)
  );

  llchain_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .load_en   (load_en),
    .load_data (load_data),
    .dev_ready (dev_ready),
    .dev_valid (dev_valid),
    .dev_data  (dev_data),
    .fire      (fire)
  );

  assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> !start_pend)
    else $error("start bit still set after walk began");

  assert_final_ptr_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (base_ptr[ADDR_W-1] && !busy))
    else $error("pointer register lacks end marker at done");

endmodule

// File: tb/tb_llchain_dma.sv
module tb_llchain_dma;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int NV = 4;
  localparam logic [AW-1:0] MASK = 24'h1FFFFC;

  localparam logic [31:0] V_START [0:NV-1] = '{32'h5A000100, 32'h00000203, 32'h00E00300, 32'h00000380};
  localparam logic [23:0] V_FINAL [0:NV-1] = '{24'h800000, 24'hFFFFFF, 24'h8ABCDE, 24'h900000};
  localparam int          V_WORDS [0:NV-1] = '{5, 1, 0, 4};
  localparam bit          V_THR   [0:NV-1] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cfg_we, cfg_sel;
  logic [DW-1:0] cfg_wdata;
  logic [AW-1:0] base_ptr, mem_rd_addr;
  logic          start_pend, mem_rd_req, mem_rd_valid, dev_valid, dev_ready, busy, done;
  logic [DW-1:0] mem_rd_data, dev_data;

  llchain_dma dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_ptr(base_ptr), .start_pend(start_pend), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mem [0:255];
  logic [AW-1:0] exp_addr [0:63];
  logic [DW-1:0] exp_data [0:63];
  int exp_na, exp_nd, got_na, got_nd, done_cnt, cyc;
  bit thr, mon_on, rd_pipe, stall_pend, done_prev, busy_prev;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] stall_data;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference walk built from the requirements
  task automatic ref_walk(input logic [AW-1:0] start, output int words, output logic [AW-1:0] fin);
    logic [AW-1:0] cur;
    logic [31:0] h;
    cur = start; exp_na = 0; exp_nd = 0;
    forever begin
      exp_addr[exp_na] = cur & MASK; exp_na++;
      h = mem[(cur & MASK) >> 2];
      cur = cur + 24'd4;
      for (int i = 0; i < int'(h[31:24]); i++) begin
        exp_addr[exp_na] = cur & MASK; exp_na++;
        exp_data[exp_nd] = mem[(cur & MASK) >> 2]; exp_nd++;
        cur = cur + 24'd4;
      end
      cur = h[23:0];
      if (cur[23]) break;
    end
    words = exp_nd; fin = cur;
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // memory responder (fixed latency) and output monitor
  always @(negedge clk) begin
    cyc++;
    mem_rd_valid = rd_pipe;
    if (rd_pipe) mem_rd_data = mem[(rd_addr_q & MASK) >> 2];
    rd_pipe = mem_rd_req;
    rd_addr_q = mem_rd_addr;
    dev_ready = thr ? ((cyc % 3) != 0) : 1'b1;
    if (mon_on) begin
      if (mem_rd_req) begin
        if (got_na < exp_na) check(mem_rd_addr == exp_addr[got_na], "R5 read address", {8'h0, mem_rd_addr}, {8'h0, exp_addr[got_na]});
        else check(1'b0, "R2 extra read", {8'h0, mem_rd_addr}, 32'h0);
        check(!dev_valid, "R10 read while word waiting", {31'h0, dev_valid}, 32'h0);
        got_na++;
      end
      if (stall_pend) check(dev_valid && dev_data == stall_data, "R10 stall hold", dev_data, stall_data);
      stall_pend = 1'b0;
      if (dev_valid && dev_ready) begin
        if (got_nd < exp_nd) check(dev_data == exp_data[got_nd], "R2 payload", dev_data, exp_data[got_nd]);
        else check(1'b0, "R3 extra payload", dev_data, 32'h0);
        got_nd++;
      end else if (dev_valid) begin
        stall_pend = 1'b1; stall_data = dev_data;
      end
      if (done) begin
        done_cnt++;
        check(!busy && busy_prev, "R9 busy around done", {31'h0, busy}, 32'h0);
        check(!done_prev, "R9 done width", {31'h0, done_prev}, 32'h0);
      end
      done_prev = done; busy_prev = busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int words, d0, w;
    logic [AW-1:0] fin;
    cyc = 0; thr = 1'b0; mon_on = 1'b0; rd_pipe = 1'b0; stall_pend = 1'b0;
    done_prev = 1'b0; busy_prev = 1'b0; done_cnt = 0; got_na = 0; got_nd = 0;
    exp_na = 0; exp_nd = 0;
    mem_rd_valid = 1'b0; mem_rd_data = '0; dev_ready = 1'b1;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = {16'hC0DE, 8'(i), 8'(~i)};
    mem[64]  = 32'h02000120;  // 2 words, next 0x120
    mem[72]  = 32'h00400140;  // empty node, next aliases to 0x140
    mem[80]  = 32'h03800000;  // 3 words, end
    mem[128] = 32'h01FFFFFF;  // 1 word, end
    mem[192] = 32'h008ABCDE;  // empty node, end
    mem[224] = 32'h04900000;  // 4 words, end

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R9 reset busy/done", {30'h0, busy, done}, 32'h0);
    check(!dev_valid && !mem_rd_req, "R10 reset outputs", {30'h0, dev_valid, mem_rd_req}, 32'h0);
    check(base_ptr == '0 && !start_pend, "R6 reset regs", {7'h0, start_pend, base_ptr}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    for (int v = 0; v < NV; v++) begin
      thr = V_THR[v];
      ref_walk(V_START[v][AW-1:0], words, fin);
      check(words == V_WORDS[v] && fin == V_FINAL[v], "R1 reference chain", words, V_WORDS[v]);
      got_na = 0; got_nd = 0; d0 = done_cnt;
      cfg_write(1'b0, V_START[v]);
      check(base_ptr == V_START[v][AW-1:0], "R8 pointer write", {8'h0, base_ptr}, {8'h0, V_START[v][AW-1:0]});
      cfg_write(1'b1, 32'h1);
      check(start_pend, "R6 start bit set", {31'h0, start_pend}, 32'h1);
      @(negedge clk);
      check(busy && !start_pend, "R6 start cleared at begin", {30'h0, busy, start_pend}, 32'h2);
      w = 0;
      while (done_cnt == d0 && w < 5000) begin
        @(negedge clk); w++;
      end
      check(w < 5000, "R4 walk terminates", w, 5000);
      @(negedge clk);
      check(base_ptr == V_FINAL[v], "R7 final pointer", {8'h0, base_ptr}, {8'h0, V_FINAL[v]});
      check(base_ptr[23], "R4 end marker", {8'h0, base_ptr}, {8'h0, V_FINAL[v]});
      check(got_nd == V_WORDS[v], "R3 payload count", got_nd, V_WORDS[v]);
      check(got_na == exp_na, "R2 read count", got_na, exp_na);
    end

    // directed: upper byte of pointer writes discarded
    cfg_write(1'b0, 32'hFFFFFFFF);
    check(base_ptr == 24'hFFFFFF, "R8 all ones", {8'h0, base_ptr}, 32'h00FFFFFF);
    cfg_write(1'b0, 32'h12345678);
    check(base_ptr == 24'h345678, "R8 upper byte", {8'h0, base_ptr}, 32'h00345678);
    // directed: idle stays quiet with no start
    d0 = done_cnt;
    repeat (6) @(negedge clk);
    check(done_cnt == d0 && !busy && !mem_rd_req, "R9 idle quiet", done_cnt, d0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule